// File: doc/BRIEF.md
# Rank-Order Histogram Equalization Quantizer

This block assigns an equalized grey level to each pixel of a frame whose address events arrive already sorted from brightest to darkest, as they do from a time-to-first-spike sensor. No histogram is stored. The grey level of an event depends only on its position in the arrival order. A 5-bit prescaler and a toggle stage count 64 accepted events for every level. An 8-bit level counter starts at the top code and steps down once per group. The first 64 pixels of a 128x128 frame therefore receive code 255, the next 64 receive 254, and so on. Each of the 256 codes covers exactly 64 pixels.

Events enter through a valid/ready handshake. Each event carries a 7-bit row and a 7-bit column. One cycle after an event is accepted, the block emits a single output word that holds the grey code and the address. A frame-start pulse rearms the counters for the next frame. A mode input selects between equalized output and raw capture. In raw capture the address passes through with a zero code, but the event still counts toward the rank.

Top module: `rank_eq_quantizer`

## Requirements
- R1: After reset, and in the cycle after a frame-start pulse, the block is rearmed: frame_done is low, out_valid is low, and the first event accepted afterwards in equalize mode gets code 255.
- R2: In equalize mode, the accepted event with rank k (counting from 0 since the frame was rearmed) gets code 255 - floor(k/64). Every code value is given to exactly 64 consecutive events.
- R3: Once the level has reached 0 it holds at 0 and never wraps. Events accepted after the 16384th get code 0.
- R4: frame_done goes high in the cycle after the 16384th accepted event. It stays high until the next frame-start pulse.
- R5: Only accepted transfers (in_valid and in_ready both high) advance the rank; idle cycles do not. in_ready is low during a frame-start cycle. An event offered in that cycle is dropped and produces no output.
- R6: out_valid is high exactly in the cycle after each accepted event, and out_word carries that event's address.
- R7: With mode_eq low (raw capture), the code field is 0 and the address passes through unchanged. The event still advances the rank, so later equalized events keep their rank-based codes.
- R8: A frame-start pulse in the middle of a frame restarts the ranking, so the next accepted event gets code 255.
- R9: out_word is laid out as {code[21:14], row[13:7], col[6:0]}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| frame_start | input | 1 | One-cycle pulse that rearms the block for a new frame |
| mode_eq | input | 1 | 1 = equalized code, 0 = raw capture (code forced to 0) |
| in_valid | input | 1 | An address event is offered |
| in_ready | output | 1 | The block accepts the offered event |
| in_row | input | 7 | Row address of the event |
| in_col | input | 7 | Column address of the event |
| out_valid | output | 1 | out_word holds a new result |
| out_word | output | 22 | {code, row, col} |
| frame_done | output | 1 | 16384 events have been accepted since rearm |

## Verification
The bench first streams events back to back and then with idle gaps, and checks that codes fall exactly on the 64-event boundaries. This tells rank counting apart from cycle counting. A stretch of raw-capture events followed by equalized events shows whether raw events still advance the rank. A full frame of 16384 events, followed by extra events, checks the last group, the hold at code 0 with no wrap, and the cycle in which frame_done rises. Rearming in the middle of a frame, with an event offered in the same cycle, confirms that ranking restarts at 255 and that the offered event is dropped.

// File: rtl/rank_eq_pkg.sv
package rank_eq_pkg;
    localparam int ROW_W = 7;
    localparam int COL_W = 7;
    localparam int LVL_W = 8;
    localparam int PRE_W = 5;
endpackage

// File: rtl/rank_eq_counter.sv
module rank_eq_counter #(
    parameter int LVL_W = 8,
    parameter int PRE_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rearm,
    input  logic             accept,
    output logic [LVL_W-1:0] level,
    output logic             done
);
    localparam logic [LVL_W-1:0] LVL_TOP = {LVL_W{1'b1}};
    localparam logic [PRE_W-1:0] PRE_TOP = {PRE_W{1'b1}};

    typedef struct packed {
        logic [PRE_W-1:0] pre;
        logic             tog;
        logic [LVL_W-1:0] lvl;
        logic             done;
    } cnt_t;

    cnt_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (rearm) begin
            st_d.pre  = '0;
            st_d.tog  = 1'b0;
            st_d.lvl  = LVL_TOP;
            st_d.done = 1'b0;
        end else if (accept) begin
            st_d.pre = st_q.pre + 1'b1;
            if (st_q.pre == PRE_TOP) begin
                st_d.tog = ~st_q.tog;
                if (st_q.tog) begin
                    if (st_q.lvl == '0) begin
                        st_d.done = 1'b1;
                    end else begin
                        st_d.lvl = st_q.lvl - 1'b1;
                    end
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{pre: '0, tog: 1'b0, lvl: LVL_TOP, done: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign level = st_q.lvl;
    assign done  = st_q.done;

    assert_rearm_R1: assert property (@(posedge clk) disable iff (!rst_n)
        rearm |=> (st_q.lvl == LVL_TOP) && (st_q.pre == '0) && !st_q.done);

    assert_monotone_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !rearm |=> st_q.lvl <= $past(st_q.lvl));

    assert_no_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.lvl == '0) && !rearm |=> st_q.lvl == '0);

    assert_done_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.done && !rearm |=> st_q.done);

    assert_idle_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !accept && !rearm |=> $stable(st_q.lvl) && $stable(st_q.pre) && $stable(st_q.tog));
endmodule

// File: rtl/rank_eq_outstage.sv
module rank_eq_outstage #(
    parameter int LVL_W = 8,
    parameter int ROW_W = 7,
    parameter int COL_W = 7
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         accept,
    input  logic                         mode_eq,
    input  logic [LVL_W-1:0]             level,
    input  logic [ROW_W-1:0]             row,
    input  logic [COL_W-1:0]             col,
    output logic                         out_valid,
    output logic [LVL_W+ROW_W+COL_W-1:0] out_word
);
    localparam int WORD_W = LVL_W + ROW_W + COL_W;

    typedef struct packed {
        logic              vld;
        logic [WORD_W-1:0] word;
    } out_t;

    out_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.vld = accept;
        if (accept) begin
            st_d.word = {(mode_eq ? level : {LVL_W{1'b0}}), row, col};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid = st_q.vld;
    assign out_word  = st_q.word;

    assert_latency_R6: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> out_valid && (out_word[ROW_W+COL_W-1:0] == $past({row, col})));

    assert_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !accept |=> !out_valid);

    assert_raw_code_R7: assert property (@(posedge clk) disable iff (!rst_n)
        accept && !mode_eq |=> out_word[WORD_W-1:ROW_W+COL_W] == '0);
endmodule

// File: rtl/rank_eq_quantizer.sv
module rank_eq_quantizer
    import rank_eq_pkg::*;
#(
    parameter int P_ROW_W = ROW_W,
    parameter int P_COL_W = COL_W,
    parameter int P_LVL_W = LVL_W,
    parameter int P_PRE_W = PRE_W
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic                                 frame_start,
    input  logic                                 mode_eq,
    input  logic                                 in_valid,
    output logic                                 in_ready,
    input  logic [P_ROW_W-1:0]                   in_row,
    input  logic [P_COL_W-1:0]                   in_col,
    output logic                                 out_valid,
    output logic [P_LVL_W+P_ROW_W+P_COL_W-1:0]   out_word,
    output logic                                 frame_done
);
    logic               accept;
    logic [P_LVL_W-1:0] level;

    assign in_ready = ~frame_start;
    assign accept   = in_valid & in_ready;

    rank_eq_counter #(
        .LVL_W(P_LVL_W),
        .PRE_W(P_PRE_W)
    ) u_counter (
        .clk   (clk),
        .rst_n (rst_n),
        .rearm (frame_start),
        .accept(accept),
        .level (level),
        .done  (frame_done)
    );

    rank_eq_outstage #(
        .LVL_W(P_LVL_W),
        .ROW_W(P_ROW_W),
        .COL_W(P_COL_W)
    ) u_out (
        .clk      (clk),
        .rst_n    (rst_n),
        .accept   (accept),
        .mode_eq  (mode_eq),
        .level    (level),
        .row      (in_row),
        .col      (in_col),
        .out_valid(out_valid),
        .out_word (out_word)
    );

    assert_drop_on_start_R5: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |=> !out_valid && !frame_done);
endmodule

// File: tb/rank_eq_quantizer_bench.sv
module rank_eq_quantizer_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        frame_start = 1'b0;
    logic        mode_eq = 1'b1;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [6:0]  in_row = '0;
    logic [6:0]  in_col = '0;
    logic        out_valid;
    logic [21:0] out_word;
    logic        frame_done;

    int checks = 0;
    int fails = 0;
    int rank = 0;
    bit finished = 1'b0;
    logic [21:0] expq[$];
    string tagq[$];

    always #4 clk = ~clk;

    rank_eq_quantizer u_rank_eq_quantizer (
        .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .mode_eq(mode_eq),
        .in_valid(in_valid), .in_ready(in_ready), .in_row(in_row), .in_col(in_col),
        .out_valid(out_valid), .out_word(out_word), .frame_done(frame_done)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] model_code(input int k, input logic m);
        if (!m) return 8'd0;
        if (k >= 16384) return 8'd0;
        return 8'(255 - k / 64);
    endfunction

    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            if (expq.size() == 0) begin
                check("R6 unexpected out_valid", 32'(out_valid), 32'd0);
            end else begin
                check(tagq.pop_front(), 32'(out_word), 32'(expq.pop_front()));
            end
        end
    end

    task automatic send(input logic m, input string req);
        logic [6:0] r = 7'((rank * 5 + 3) >> 7);
        logic [6:0] c = 7'(rank * 13 + 1);
        @(negedge clk);
        in_valid = 1'b1; mode_eq = m; in_row = r; in_col = c;
        expq.push_back({model_code(rank, m), r, c});
        tagq.push_back(req);
        rank++;
        @(posedge clk);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
        end
    endtask

    task automatic rearm();
        @(negedge clk);
        frame_start = 1'b1; in_valid = 1'b1; in_row = 7'h55; in_col = 7'h2a;
        #1 check("R5 in_ready low during frame start", 32'(in_ready), 32'd0);
        rank = 0;
        @(negedge clk);
        frame_start = 1'b0; in_valid = 1'b0;
        check("R1 frame_done low after rearm", 32'(frame_done), 32'd0);
        check("R5 dropped event gives no output", 32'(out_valid), 32'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1 out_valid at reset", 32'(out_valid), 32'd0);
        check("R1 frame_done at reset", 32'(frame_done), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R5 in_ready idle", 32'(in_ready), 32'd1);

        for (int i = 0; i < 70; i++) send(1'b1, "R1 R2 R9 streamed code");
        for (int i = 0; i < 70; i++) begin
            send(1'b1, "R2 R5 gapped code");
            if (i % 7 == 3) idle(2);
        end
        idle(2);
        check("R6 out_valid low when idle", 32'(out_valid), 32'd0);

        rearm();
        send(1'b1, "R8 restart at 255");
        for (int i = 0; i < 69; i++) send(1'b0, "R7 raw capture zero code");
        for (int i = 0; i < 10; i++) send(1'b1, "R7 rank kept after raw");
        idle(1);

        while (rank < 16383) send(1'b1, "R2 full frame code");
        idle(1);
        check("R4 frame_done low before last event", 32'(frame_done), 32'd0);
        send(1'b1, "R2 last group code 0");
        @(negedge clk);
        in_valid = 1'b0;
        check("R4 frame_done after 16384 events", 32'(frame_done), 32'd1);
        for (int i = 0; i < 70; i++) send(1'b1, "R3 hold at zero no wrap");
        idle(2);
        check("R4 frame_done sticky", 32'(frame_done), 32'd1);

        rearm();
        send(1'b1, "R1 R8 first code after rearm");
        idle(3);
        check("R6 all results delivered", 32'(expq.size()), 32'd0);

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end
endmodule